// File: doc/BRIEF.md
# Non-Binary to Binary Code Encoder

A converter that settles one bit per step with a radix between one and two produces a redundant code. Each bit carries a non-integer weight. This block turns that code into a plain binary value. It receives the bits of one conversion serially, first decision first, and packs them into a parallel word. It then walks the word one position per clock. For each set bit it fetches a precomputed fractional weight from a coefficient table and adds it to a running sum. No multiplier is involved.

The weight table is indexed by bit position and by a 7-bit radix select. The radix select picks one of 128 evenly spaced radix values from 1.7869 up to 1.9000. The table contents are computed when the design is elaborated, using integer fixed-point arithmetic. The final sum is rounded to 12 bits and saturated. The result is presented together with a one-cycle completion pulse. Normally the radix select comes from a separate estimation loop, which is not part of this block.

Top module: `nbe_encoder`

## Requirements
- R1: While reset is asserted, and after it is released, `code_o` is 0 and `done_o` is 0 until the first conversion completes. An asynchronous reset in the middle of a conversion discards the partial bits.
- R2: A conversion consists of 16 bits, each taken on a clock edge where `bit_vld_i` is 1. The first bit taken is position 1, the heaviest, and uses table row 0. The sixteenth bit uses row 15.
- R3: When `conv_start_i` is 1 on an edge where `bit_vld_i` is 1, that bit becomes position 1 of a new conversion, and any partially collected bits are dropped.
- R4: Clock edges where `bit_vld_i` is 0 take no bit. The value of `sample_bit_i` on those edges has no effect on the result.
- R5: The weight of position L at radix select k is round(65536·(β−1)/β^L), with β = 1.7869 + k·0.1131/127.
- R6: `code_o` equals floor((S+8)/16), where S is the sum of the weights of all set bits. Any value above 4095 is clamped to 4095, so sixteen ones at k=0 give 4095. A word of all zeros gives 0.
- R7: `radix_sel_i` is sampled only on the edge that takes the sixteenth bit. Its value on any other edge has no effect.
- R8: `done_o` is high for exactly one cycle. It rises 17 clock edges after the edge that took the sixteenth bit.
- R9: `code_o` changes only in the cycle in which `done_o` is high, and it holds its value until the next completion.
- R10: The first bit of the next conversion may arrive on the edge right after the sixteenth bit of the current one. Both conversions then produce correct results in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_bit_i | input | 1 | Serial non-binary bit |
| bit_vld_i | input | 1 | Qualifies `sample_bit_i` on this edge |
| conv_start_i | input | 1 | Marks the current valid bit as position 1 |
| radix_sel_i | input | 7 | Radix step select, 0 gives 1.7869 and 127 gives 1.9000 |
| code_o | output | 12 | Rounded, saturated binary result |
| done_o | output | 1 | One-cycle pulse when `code_o` is updated |

## Verification
The bench builds its expected codes from real-valued powers of the radix. Bit-order mistakes therefore show up directly: a design that weighted the first bit with the lightest row would return a code near zero for a lone leading one. A design that missed the rounding offset or the clamp would return an off-by-one value or a wrapped small code for sixteen ones at the lowest radix.

The bench scrambles the radix select on every edge except the sixteenth. It also toggles the data line during invalid cycles and injects a restart after a partial word. A design that sampled the select late, took invalid bits, or kept stale bits would produce a wrong code. The bench also sends back-to-back words. A design that could not load a new word while finishing the previous one would lose the second result.

// File: rtl/nbe_pkg.sv
package nbe_pkg;

  // Radix range in units of 1e-4: lowest value and total span over all steps.
  localparam int RADIX_LO    = 17869;
  localparam int RADIX_SPAN  = 1131;
  localparam int RADIX_SCALE = 10000;
  // Internal precision (fraction bits) used while building the table.
  localparam int CALC_FRAC   = 40;

  // Weight (beta-1)/beta^(pos+1) as an unsigned fraction with frac_w bits,
  // rounded to nearest. beta = num/den, computed with integer arithmetic only.
  function automatic logic [31:0] nbe_weight(input int step, input int pos,
                                             input int steps, input int frac_w);
    logic [63:0] den;
    logic [63:0] num;
    logic [63:0] w;
    den = 64'(RADIX_SCALE) * 64'(steps - 1);
    num = 64'(RADIX_LO) * 64'(steps - 1) + 64'(RADIX_SPAN) * 64'(step);
    w   = ((num - den) << CALC_FRAC) / num;
    for (int i = 0; i < pos; i++) begin
      w = (w * den) / num;
    end
    w = (w + (64'd1 << (CALC_FRAC - frac_w - 1))) >> (CALC_FRAC - frac_w);
    return w[31:0];
  endfunction

endpackage

// File: rtl/nbe_deser.sv
module nbe_deser #(
  parameter int NB_BITS = 16,
  parameter int COL_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               vld_i,
  input  logic               bit_i,
  input  logic [COL_W-1:0]   col_i,
  output logic [NB_BITS-1:0] word_o,
  output logic [COL_W-1:0]   col_o,
  output logic               word_vld_o,
  output logic [$clog2(NB_BITS)-1:0] cnt_o
);

  localparam int CNT_W = $clog2(NB_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NB_BITS - 1);

  logic [NB_BITS-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d, cnt_base;
  logic [COL_W-1:0]   col_q, col_d;
  logic               wv_q, wv_d;
  logic               shift_en, col_en;

  // next-state
  always_comb begin
    cnt_base = start_i ? '0 : cnt_q;
    shift_d  = start_i ? {{(NB_BITS-1){1'b0}}, bit_i}
                       : {shift_q[NB_BITS-2:0], bit_i};
    shift_en = vld_i;
    cnt_d    = cnt_q;
    col_d    = col_q;
    col_en   = 1'b0;
    wv_d     = 1'b0;
    if (vld_i) begin
      if (cnt_base == LAST) begin
        cnt_d  = '0;
        wv_d   = 1'b1;
        col_d  = col_i;
        col_en = 1'b1;
      end else begin
        cnt_d = cnt_base + CNT_W'(1);
      end
    end else if (start_i) begin
      cnt_d = '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
      col_q   <= '0;
      wv_q    <= 1'b0;
    end else begin
      if (shift_en) shift_q <= shift_d;
      if (col_en)   col_q   <= col_d;
      cnt_q <= cnt_d;
      wv_q  <= wv_d;
    end
  end

  assign word_o     = shift_q;
  assign col_o      = col_q;
  assign word_vld_o = wv_q;
  assign cnt_o      = cnt_q;

endmodule

// File: rtl/nbe_coef_rom.sv
module nbe_coef_rom #(
  parameter int NB_BITS = 16,
  parameter int COL_W   = 7,
  parameter int FRAC_W  = 16
) (
  input  logic [COL_W-1:0]           col_i,
  input  logic [$clog2(NB_BITS)-1:0] row_i,
  output logic [FRAC_W-1:0]          w_o
);

  localparam int ROW_W = $clog2(NB_BITS);
  localparam int STEPS = 1 << COL_W;
  localparam int DEPTH = STEPS * NB_BITS;

  logic [FRAC_W-1:0] tbl [DEPTH];

  for (genvar r = 0; r < STEPS; r++) begin : g_col
    for (genvar l = 0; l < NB_BITS; l++) begin : g_row
      localparam logic [31:0] WFULL = nbe_pkg::nbe_weight(r, l, STEPS, FRAC_W);
      assign tbl[r*NB_BITS + l] = WFULL[FRAC_W-1:0];
    end
  end

  assign w_o = tbl[{col_i, row_i}];

endmodule

// File: rtl/nbe_accum.sv
module nbe_accum #(
  parameter int NB_BITS = 16,
  parameter int COL_W   = 7,
  parameter int FRAC_W  = 16,
  parameter int OUT_W   = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_i,
  input  logic [NB_BITS-1:0]         word_i,
  input  logic [COL_W-1:0]           col_i,
  output logic [COL_W-1:0]           rom_col_o,
  output logic [$clog2(NB_BITS)-1:0] rom_row_o,
  input  logic [FRAC_W-1:0]          rom_w_i,
  output logic [OUT_W-1:0]           code_o,
  output logic                       done_o,
  output logic                       busy_o
);

  localparam int ROW_W = $clog2(NB_BITS);
  localparam int ACC_W = FRAC_W + ROW_W;
  localparam int SHIFT = FRAC_W - OUT_W;
  localparam int Q_W   = ACC_W + 1 - SHIFT;
  localparam logic [ROW_W-1:0] LAST_POS = ROW_W'(NB_BITS - 1);
  localparam logic [ACC_W:0]   HALF     = (ACC_W+1)'(1 << (SHIFT - 1));
  localparam logic [Q_W-1:0]   MAXC     = Q_W'((1 << OUT_W) - 1);

  logic               busy_q, busy_d;
  logic [ROW_W-1:0]   pos_q, pos_d;
  logic [ACC_W-1:0]   acc_q, acc_d, acc_sum;
  logic [NB_BITS-1:0] word_q, word_d;
  logic [COL_W-1:0]   col_q, col_d;
  logic [OUT_W-1:0]   code_q, code_d;
  logic               done_d, done_q;
  logic               cur_bit, last_step, take;
  logic [ACC_W:0]     rnd;
  logic [Q_W-1:0]     quo;
  logic [OUT_W-1:0]   sat_code;

  assign rom_col_o = col_q;
  assign rom_row_o = pos_q;
  assign cur_bit   = word_q[LAST_POS - pos_q];
  assign last_step = busy_q && (pos_q == LAST_POS);
  assign take      = load_i && (!busy_q || last_step);

  // rounding and clamp of the completed sum
  always_comb begin
    acc_sum  = acc_q + (cur_bit ? ACC_W'(rom_w_i) : '0);
    rnd      = {1'b0, acc_sum} + HALF;
    quo      = rnd[ACC_W:SHIFT];
    sat_code = (quo > MAXC) ? {OUT_W{1'b1}} : quo[OUT_W-1:0];
  end

  // next-state
  always_comb begin
    busy_d = busy_q;
    pos_d  = pos_q;
    acc_d  = acc_q;
    word_d = word_q;
    col_d  = col_q;
    code_d = code_q;
    done_d = 1'b0;
    if (busy_q) begin
      acc_d = acc_sum;
      if (last_step) begin
        busy_d = 1'b0;
        code_d = sat_code;
        done_d = 1'b1;
      end else begin
        pos_d = pos_q + ROW_W'(1);
      end
    end
    if (take) begin
      busy_d = 1'b1;
      pos_d  = '0;
      acc_d  = '0;
      word_d = word_i;
      col_d  = col_i;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pos_q  <= '0;
      acc_q  <= '0;
      word_q <= '0;
      col_q  <= '0;
      code_q <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (busy_q || take) begin
        pos_q <= pos_d;
        acc_q <= acc_d;
      end
      if (take) begin
        word_q <= word_d;
        col_q  <= col_d;
      end
      if (done_d) code_q <= code_d;
    end
  end

  assign code_o = code_q;
  assign done_o = done_q;
  assign busy_o = busy_q;

endmodule

// File: rtl/nbe_encoder.sv
module nbe_encoder #(
  parameter int NB_BITS = 16,
  parameter int COL_W   = 7,
  parameter int FRAC_W  = 16,
  parameter int OUT_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_bit_i,
  input  logic             bit_vld_i,
  input  logic             conv_start_i,
  input  logic [COL_W-1:0] radix_sel_i,
  output logic [OUT_W-1:0] code_o,
  output logic             done_o
);

  localparam int ROW_W = $clog2(NB_BITS);

  logic [1:0]         rst_pipe_q;
  logic               rst_sync_n;
  logic [NB_BITS-1:0] word;
  logic [COL_W-1:0]   word_col;
  logic               word_vld;
  logic [ROW_W-1:0]   bit_cnt;
  logic [COL_W-1:0]   rom_col;
  logic [ROW_W-1:0]   rom_row;
  logic [FRAC_W-1:0]  rom_w;
  logic               enc_busy;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  nbe_deser #(.NB_BITS(NB_BITS), .COL_W(COL_W)) u_deser (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (conv_start_i),
    .vld_i      (bit_vld_i),
    .bit_i      (sample_bit_i),
    .col_i      (radix_sel_i),
    .word_o     (word),
    .col_o      (word_col),
    .word_vld_o (word_vld),
    .cnt_o      (bit_cnt)
  );

  nbe_coef_rom #(.NB_BITS(NB_BITS), .COL_W(COL_W), .FRAC_W(FRAC_W)) u_rom (
    .col_i (rom_col),
    .row_i (rom_row),
    .w_o   (rom_w)
  );

  nbe_accum #(.NB_BITS(NB_BITS), .COL_W(COL_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_accum (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_i    (word_vld),
    .word_i    (word),
    .col_i     (word_col),
    .rom_col_o (rom_col),
    .rom_row_o (rom_row),
    .rom_w_i   (rom_w),
    .code_o    (code_o),
    .done_o    (done_o),
    .busy_o    (enc_busy)
  );

endmodule

// File: rtl/nbe_encoder_chk.sv
module nbe_encoder_chk #(
  parameter int CNT_W = 4,
  parameter int OUT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_vld_i,
  input logic             conv_start_i,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             word_vld,
  input logic             enc_busy,
  input logic [OUT_W-1:0] code_o,
  input logic             done_o
);

  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(code_o));

  // R4
  idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld_i && !conv_start_i) |=> $stable(bit_cnt));

  // R3
  restart_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start_i && bit_vld_i) |=> (bit_cnt == CNT_W'(1)));

  // R2
  word_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_vld_i && !conv_start_i && bit_cnt == LAST) |=> word_vld);

  // R8
  load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> enc_busy);

endmodule

bind nbe_encoder nbe_encoder_chk #(.CNT_W($clog2(NB_BITS)), .OUT_W(OUT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .bit_vld_i    (bit_vld_i),
  .conv_start_i (conv_start_i),
  .bit_cnt      (bit_cnt),
  .word_vld     (word_vld),
  .enc_busy     (enc_busy),
  .code_o       (code_o),
  .done_o       (done_o)
);

// File: tb/nbe_encoder_bench.sv
module nbe_encoder_bench;

  // clock period 10 time units = 10 ns, i.e. 100 MHz
  localparam int NV       = 9;
  localparam int POLL_LAT = 18; // done rises 17 edges after 16th bit; seen on next poll

  localparam logic [15:0] VEC_W [NV] = '{16'h0000, 16'hFFFF, 16'h8000, 16'h8000,
                                         16'hAAAA, 16'h5555, 16'h7FFF, 16'h0001, 16'h6E3B};
  localparam logic [6:0]  VEC_R [NV] = '{7'd0, 7'd0, 7'd0, 7'd127,
                                         7'd64, 7'd33, 7'd127, 7'd100, 7'd17};

  logic        clk;
  logic        rst_n;
  logic        sample_bit_i;
  logic        bit_vld_i;
  logic        conv_start_i;
  logic [6:0]  radix_sel_i;
  logic [11:0] code_o;
  logic        done_o;

  int total = 0;
  int bad   = 0;
  int ncap  = 0;
  int dbl   = 0;
  logic        prev_done = 1'b0;
  logic [11:0] cap [8];

  nbe_encoder u_nbe_encoder (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_bit_i (sample_bit_i),
    .bit_vld_i    (bit_vld_i),
    .conv_start_i (conv_start_i),
    .radix_sel_i  (radix_sel_i),
    .code_o       (code_o),
    .done_o       (done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // completion monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      cap[ncap % 8] = code_o;
      ncap = ncap + 1;
      if (prev_done) dbl = dbl + 1;
    end
    prev_done = rst_n && done_o;
  end

  function automatic int model(input logic [15:0] w, input int k);
    real b;
    real p;
    int  s;
    int  r;
    b = 1.7869 + real'(k) * 0.1131 / 127.0;
    p = 1.0;
    s = 0;
    for (int l = 1; l <= 16; l++) begin
      p = p * b;
      if (w[16 - l]) s = s + $rtoi((b - 1.0) / p * 65536.0 + 0.5);
    end
    r = (s + 8) / 16;
    if (r > 4095) r = 4095;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [15:0] w, input logic [6:0] rad,
                           input bit st, input bit gaps, input bit trail);
    for (int i = 0; i < 16; i++) begin
      if (gaps) begin
        @(negedge clk);
        bit_vld_i    = 1'b0;
        conv_start_i = 1'b0;
        sample_bit_i = ~w[15 - i];
        radix_sel_i  = ~rad;
      end
      @(negedge clk);
      bit_vld_i    = 1'b1;
      sample_bit_i = w[15 - i];
      conv_start_i = st && (i == 0);
      radix_sel_i  = (i == 15) ? rad : ~rad; // R7: only the 16th edge counts
    end
    if (trail) begin
      @(negedge clk);
      bit_vld_i    = 1'b0;
      conv_start_i = 1'b0;
      sample_bit_i = 1'b1;
      radix_sel_i  = ~rad;
    end
  endtask

  task automatic wait_done(input int target, output int lat);
    lat = 0;
    while (ncap <= target && lat < 200) begin
      @(posedge clk);
      lat++;
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat;
    int base;
    int e;
    logic [11:0] held;
    rst_n        = 1'b0;
    sample_bit_i = 1'b0;
    bit_vld_i    = 1'b0;
    conv_start_i = 1'b0;
    radix_sel_i  = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(code_o == 12'd0, "R1 code in reset", int'(code_o), 0);
    chk(done_o == 1'b0, "R1 done in reset", int'(done_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(code_o == 12'd0 && done_o == 1'b0, "R1 after release", int'(code_o), 0);

    // vector table: R2 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      base = ncap;
      send_word(VEC_W[v], VEC_R[v], (v == 0), 1'b0, 1'b1);
      wait_done(base, lat);
      e = model(VEC_W[v], int'(VEC_R[v]));
      chk(ncap == base + 1 && int'(cap[base % 8]) == e, "R2 R5 R6 R7 code", int'(cap[base % 8]), e);
      chk(lat == POLL_LAT, "R8 latency", lat, POLL_LAT);
    end

    // R6 saturation and zero, stated explicitly
    base = ncap;
    send_word(16'hFFFF, 7'd0, 1'b0, 1'b0, 1'b1);
    wait_done(base, lat);
    chk(cap[base % 8] == 12'd4095, "R6 clamp", int'(cap[base % 8]), 4095);
    base = ncap;
    send_word(16'h0000, 7'd90, 1'b0, 1'b0, 1'b1);
    wait_done(base, lat);
    chk(cap[base % 8] == 12'd0, "R6 zero word", int'(cap[base % 8]), 0);

    // R9 hold after completion, R8 pulse width
    held = code_o;
    repeat (6) @(negedge clk);
    chk(code_o == held, "R9 hold", int'(code_o), int'(held));
    chk(done_o == 1'b0, "R8 done low", int'(done_o), 0);

    // R3 restart after a partial word
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      bit_vld_i    = 1'b1;
      sample_bit_i = 1'b1;
    end
    base = ncap;
    send_word(16'h1234, 7'd45, 1'b1, 1'b0, 1'b1);
    wait_done(base, lat);
    e = model(16'h1234, 45);
    chk(ncap == base + 1 && int'(cap[base % 8]) == e, "R3 restart", int'(cap[base % 8]), e);

    // R4 idle cycles with a toggling data line
    base = ncap;
    send_word(16'hC3A5, 7'd77, 1'b0, 1'b1, 1'b1);
    wait_done(base, lat);
    e = model(16'hC3A5, 77);
    chk(int'(cap[base % 8]) == e, "R4 invalid bits ignored", int'(cap[base % 8]), e);

    // R10 back-to-back conversions
    base = ncap;
    send_word(16'h9F01, 7'd5, 1'b0, 1'b0, 1'b0);
    send_word(16'h4C7E, 7'd120, 1'b0, 1'b0, 1'b1);
    wait_done(base + 1, lat);
    e = model(16'h9F01, 5);
    chk(ncap == base + 2 && int'(cap[base % 8]) == e, "R10 first", int'(cap[base % 8]), e);
    e = model(16'h4C7E, 120);
    chk(int'(cap[(base + 1) % 8]) == e, "R10 second", int'(cap[(base + 1) % 8]), e);

    // R1 reset in the middle of a conversion
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      bit_vld_i    = 1'b1;
      sample_bit_i = 1'b1;
    end
    @(negedge clk);
    bit_vld_i = 1'b0;
    rst_n     = 1'b0;
    @(negedge clk);
    chk(code_o == 12'd0, "R1 mid reset clears code", int'(code_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    base = ncap;
    send_word(16'h0F0F, 7'd63, 1'b0, 1'b0, 1'b1);
    wait_done(base, lat);
    e = model(16'h0F0F, 63);
    chk(int'(cap[base % 8]) == e, "R1 clean after reset", int'(cap[base % 8]), e);

    chk(dbl == 0, "R8 single-cycle done", dbl, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule